// File: doc/BRIEF.md
# DMA Channel Request and Interrupt Register Bank

This block is the software-visible control and status bank of a multi-channel DMA engine with up to 32 channels. It holds a global control word, a request-enable mask, an error-interrupt-enable mask, and two pending vectors: one for transfer-complete events and one for channel errors. It also drives the request enables into the channel engines, and it combines the pending state into one transfer interrupt line and one error interrupt line.

Software can load a whole mask with a 32-bit write. It can also change a single channel in one bus cycle, with no read-modify-write, by writing the channel number to a byte-wide command port. Eight such ports share one doubleword. They set or clear enables, clear pending flags, and fire one-cycle start or clear-done strobes towards a channel engine. Each channel engine returns one-cycle done and error pulses.

A strap input selects a big-endian register view. In that view, narrow accesses have their byte address mirrored inside the word, and full-word data is byte-reversed. The bus is a single-cycle write strobe with a combinational read path.

Top module: `dma_ctl_regbank`

## Requirements
- R1: After reset, every readable register reads zero, and `ch_req_en`, `ch_start`, `ch_clr_done`, `irq_xfer` and `irq_err` are all low.
- R2: A byte write to the set-request port (effective address 0x1B) sets one bit of the request-enable mask, and a byte write to the clear-request port (0x1A) clears one bit. The bit is selected by bits [4:0] of the written byte; bits [7:5] are ignored. No other bit changes, and `ch_req_en` follows the mask.
- R3: A byte write to 0x19 sets one bit of the error-interrupt-enable mask, and a byte write to 0x18 clears one bit. The channel is selected in the same way as in R2.
- R4: An aligned 32-bit write to 0x0C loads the request-enable mask, and one to 0x14 loads the error-interrupt-enable mask. Both masks read back at the same addresses.
- R5: The control word at 0x00 keeps only bits 1 to 7, bit 16 and bit 17 of a 32-bit write (keep mask 0x000300FE). All other bits read zero. The kept value appears on `ctrl_word`.
- R6: A `ch_done` pulse sets the channel's bit in the interrupt-pending vector at 0x24, and `irq_xfer` is the OR of that vector. A byte write of the channel number to 0x1F clears the bit. If a done pulse and a clear land on the same channel in the same cycle, the bit stays set.
- R7: A `ch_err` pulse sets the channel's bit in the error-pending vector at 0x2C, and a byte write of the channel number to 0x1E clears it; a pulse in the same cycle as the clear wins. The error status at 0x04 holds, in bits [4:0], the lowest channel that pulsed in the most recent error cycle. Its bit 31 is set while any error is pending.
- R8: `irq_err` is high exactly when some channel has both its error-pending bit and its error-interrupt-enable bit set.
- R9: A byte write of channel n to 0x1D (start) or 0x1C (clear done) raises bit n of `ch_start` or `ch_clr_done` for exactly the one cycle after the write.
- R10: Size codes are 0 byte, 1 halfword and 2 word. With `big_endian` high, a byte access uses address XOR 3, a halfword access uses address XOR 2, and a word is byte-reversed at the same address. With `big_endian` low, addresses and data are used as given.
- R11: Byte and halfword reads return the selected lane right-aligned. Halfword writes, misaligned word writes, size code 3, and word writes to 0x04, 0x24 or 0x2C change nothing. Size code 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_endian | input | 1 | Selects the big-endian register view |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 8 | Byte address of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data; byte and halfword values are right-aligned |
| bus_rdata | output | 32 | Combinational read data for the current address and size |
| ch_done | input | NUM_CH | Per-channel transfer-complete pulses |
| ch_err | input | NUM_CH | Per-channel error pulses |
| ch_req_en | output | NUM_CH | Request-enable mask sent to the channel engines |
| ch_start | output | NUM_CH | One-cycle software start strobe per channel |
| ch_clr_done | output | NUM_CH | One-cycle clear-done strobe per channel |
| ctrl_word | output | 32 | Stored global control word |
| irq_xfer | output | 1 | Combined transfer interrupt |
| irq_err | output | 1 | Combined, enabled error interrupt |

## Verification
- **Wrong channel decode:** a fault in the command-port decode shows on `ch_req_en` or the strobe outputs one cycle after the write. It appears either as a wrong bit or as more than one bit.
- **Mishandled coincident events:** a pending vector that loses an event when a done pulse meets a clear shows at the next read of 0x24 or 0x2C, and on the interrupt lines in the same cycle.
- **Lane-mapping faults:** these show at once on `bus_rdata`, because reads are combinational. Sweeping every byte and halfword offset in both endian modes exposes any wrong lane.

// File: rtl/dma_rb_pkg.sv
// Shared constants and helpers for the DMA control register bank.
// Assumes an 8-bit byte address space and 32-bit registers.
package dma_rb_pkg;

    localparam int REG_AW   = 8;
    localparam int REG_DW   = 32;
    localparam int CH_IDX_W = 5;
    localparam int N_PORTS  = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_ESTAT = 8'h04;
    localparam logic [REG_AW-1:0] OFS_REQEN = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_ERRIE = 8'h14;
    localparam logic [REG_AW-1:0] OFS_IPEND = 8'h24;
    localparam logic [REG_AW-1:0] OFS_EPEND = 8'h2C;

    // Command ports occupy byte addresses 0x18..0x1F (address[7:3] == 3)
    localparam logic [REG_AW-4:0] PORT_BLK = 5'h03;

    typedef enum logic [2:0] {
        P_CLR_EIE   = 3'd0,
        P_SET_EIE   = 3'd1,
        P_CLR_REQ   = 3'd2,
        P_SET_REQ   = 3'd3,
        P_CLR_DONE  = 3'd4,
        P_SET_START = 3'd5,
        P_CLR_ERR   = 3'd6,
        P_CLR_INT   = 3'd7
    } cmd_port_e;

    localparam logic [REG_DW-1:0] CTRL_KEEP = 32'h0003_00FE;

    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/rb_lane_map.sv
// Endian lane mapping for the register bank.
// Produces the effective byte address, the normalised write word, and the
// lane-selected read data from a raw 32-bit register word.
// Assumes narrow data is right-aligned on the bus.
module rb_lane_map
    import dma_rb_pkg::*;
(
    input  logic              big_endian,
    input  logic [REG_AW-1:0] addr,
    input  logic [1:0]        size,
    input  logic [REG_DW-1:0] wdata,
    input  logic [REG_DW-1:0] raw_word,
    output logic [REG_AW-1:0] eff_addr,
    output logic [REG_DW-1:0] wdata_norm,
    output logic [REG_DW-1:0] rdata
);

    // Mirror narrow addresses inside the word in big-endian mode
    always_comb begin
        eff_addr = addr;
        if (big_endian) begin
            if (size == SZ_BYTE)      eff_addr = addr ^ 8'h03;
            else if (size == SZ_HALF) eff_addr = addr ^ 8'h02;
        end
    end

    // Byte-reverse full words in big-endian mode
    always_comb begin
        wdata_norm = (big_endian && size == SZ_WORD) ? swap32(wdata) : wdata;
    end

    // Select the read lane and right-align it
    always_comb begin
        logic [REG_DW-1:0] sh;
        sh = '0;
        case (size)
            SZ_BYTE: begin
                sh    = raw_word >> (8 * eff_addr[1:0]);
                rdata = {24'h0, sh[7:0]};
            end
            SZ_HALF: begin
                sh    = raw_word >> (16 * eff_addr[1]);
                rdata = {16'h0, sh[15:0]};
            end
            SZ_WORD: rdata = big_endian ? swap32(raw_word) : raw_word;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rb_port_decode.sv
// Command-port decoder: turns one byte write (port select plus channel
// index) into a one-hot channel mask per port. Masks are all zero when
// no port write is active. Assumes NUM_CH <= 32.
module rb_port_decode
    import dma_rb_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic                             wr_en,
    input  logic [2:0]                       port_sel,
    input  logic [CH_IDX_W-1:0]              chan_idx,
    output logic [N_PORTS-1:0][NUM_CH-1:0]   port_mask
);

    logic [NUM_CH-1:0] hit_ch;

    // One comparator per channel
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign hit_ch[i] = (chan_idx == CH_IDX_W'(i));
    end

    // Route the channel hit to the addressed port only
    always_comb begin
        for (int p = 0; p < N_PORTS; p++) begin
            port_mask[p] = (wr_en && port_sel == 3'(p)) ? hit_ch : '0;
        end
    end

endmodule

// File: rtl/rb_pend_vec.sv
// Pending-flag vector: a set input wins over a clear input in the same
// cycle, so no event is lost.
module rb_pend_vec #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_vec,
    input  logic [NUM_CH-1:0] clr_vec,
    output logic [NUM_CH-1:0] pend
);

    // Clear then set, with set taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | set_vec;
    end

endmodule

// File: rtl/dma_ctl_regbank.sv
// DMA channel request and interrupt register bank (top).
// Holds the control word, the request and error-interrupt enable masks,
// and the pending vectors. Decodes the byte command ports and drives the
// combined interrupts. Assumes single-cycle writes and NUM_CH <= 32.
module dma_ctl_regbank
    import dma_rb_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_err,
    output logic [NUM_CH-1:0] ch_req_en,
    output logic [NUM_CH-1:0] ch_start,
    output logic [NUM_CH-1:0] ch_clr_done,
    output logic [31:0]       ctrl_word,
    output logic              irq_xfer,
    output logic              irq_err
);

    logic [REG_AW-1:0]               eff_addr;
    logic [REG_DW-1:0]               wdata_norm;
    logic [REG_DW-1:0]               raw_word;
    logic                            port_wr;
    logic                            word_wr;
    logic [N_PORTS-1:0][NUM_CH-1:0]  pmask;
    logic [NUM_CH-1:0]               reqen_q;
    logic [NUM_CH-1:0]               errie_q;
    logic [NUM_CH-1:0]               ipend;
    logic [NUM_CH-1:0]               epend;
    logic [CH_IDX_W-1:0]             last_err_q;
    logic [CH_IDX_W-1:0]             first_err;
    logic [REG_DW-1:0]               ctrl_q;

    rb_lane_map u_lane (
        .big_endian (big_endian),
        .addr       (bus_addr),
        .size       (bus_size),
        .wdata      (bus_wdata),
        .raw_word   (raw_word),
        .eff_addr   (eff_addr),
        .wdata_norm (wdata_norm),
        .rdata      (bus_rdata)
    );

    // Classify the current write
    always_comb begin
        port_wr = bus_wr && (bus_size == SZ_BYTE) && (eff_addr[7:3] == PORT_BLK);
        word_wr = bus_wr && (bus_size == SZ_WORD) && (bus_addr[1:0] == 2'b00);
    end

    rb_port_decode #(.NUM_CH(NUM_CH)) u_dec (
        .wr_en     (port_wr),
        .port_sel  (eff_addr[2:0]),
        .chan_idx  (bus_wdata[CH_IDX_W-1:0]),
        .port_mask (pmask)
    );

    rb_pend_vec #(.NUM_CH(NUM_CH)) u_ipend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (ch_done),
        .clr_vec (pmask[P_CLR_INT]),
        .pend    (ipend)
    );

    rb_pend_vec #(.NUM_CH(NUM_CH)) u_epend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (ch_err),
        .clr_vec (pmask[P_CLR_ERR]),
        .pend    (epend)
    );

    // Control word: word writes keep only the defined bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (word_wr && eff_addr == OFS_CTRL)
            ctrl_q <= wdata_norm & CTRL_KEEP;
    end

    // Request-enable mask: whole-word load or single-channel set/clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            reqen_q <= '0;
        else if (word_wr && eff_addr == OFS_REQEN)
            reqen_q <= wdata_norm[NUM_CH-1:0];
        else
            reqen_q <= (reqen_q & ~pmask[P_CLR_REQ]) | pmask[P_SET_REQ];
    end

    // Error-interrupt-enable mask: whole-word load or single-channel set/clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            errie_q <= '0;
        else if (word_wr && eff_addr == OFS_ERRIE)
            errie_q <= wdata_norm[NUM_CH-1:0];
        else
            errie_q <= (errie_q & ~pmask[P_CLR_EIE]) | pmask[P_SET_EIE];
    end

    // Lowest-numbered channel pulsing an error this cycle
    always_comb begin
        first_err = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ch_err[i]) first_err = CH_IDX_W'(i);
        end
    end

    // Record the erroring channel number
    always_ff @(posedge clk) begin
        if (!rst_n)       last_err_q <= '0;
        else if (|ch_err) last_err_q <= first_err;
    end

    // One-cycle strobes towards the channel engines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_start    <= '0;
            ch_clr_done <= '0;
        end else begin
            ch_start    <= pmask[P_SET_START];
            ch_clr_done <= pmask[P_CLR_DONE];
        end
    end

    // Raw register word at the effective word address
    always_comb begin
        case ({eff_addr[7:2], 2'b00})
            OFS_CTRL:  raw_word = ctrl_q;
            OFS_ESTAT: raw_word = {|epend, {(REG_DW-1-CH_IDX_W){1'b0}}, last_err_q};
            OFS_REQEN: raw_word = 32'(reqen_q);
            OFS_ERRIE: raw_word = 32'(errie_q);
            OFS_IPEND: raw_word = 32'(ipend);
            OFS_EPEND: raw_word = 32'(epend);
            default:   raw_word = '0;
        endcase
    end

    // Outputs to the engines and the interrupt controller
    always_comb begin
        ch_req_en = reqen_q;
        ctrl_word = ctrl_q;
        irq_xfer  = |ipend;
        irq_err   = |(epend & errie_q);
    end

endmodule

// File: rtl/rb_checker.sv
// Port-level temporal checks for dma_ctl_regbank, attached with bind.
module rb_checker #(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_err,
    input logic [NUM_CH-1:0] ch_req_en,
    input logic [NUM_CH-1:0] ch_start,
    input logic [NUM_CH-1:0] ch_clr_done,
    input logic              irq_xfer,
    input logic              irq_err
);

    assert_start_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_start));

    assert_clrdone_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_clr_done));

    assert_done_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_done) |=> irq_xfer);

    assert_xfer_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_xfer) |-> $past(bus_wr));

    assert_reqen_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_req_en) |-> $past(bus_wr));

    assert_err_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_err) |-> ($past(bus_wr) || $past(|ch_err)));

endmodule

bind dma_ctl_regbank rb_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .ch_done     (ch_done),
    .ch_err      (ch_err),
    .ch_req_en   (ch_req_en),
    .ch_start    (ch_start),
    .ch_clr_done (ch_clr_done),
    .irq_xfer    (irq_xfer),
    .irq_err     (irq_err)
);

// File: tb/sim_dma_ctl_regbank.sv
module sim_dma_ctl_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           big_endian = 1'b0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [1:0]     bus_size = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] ch_done = '0;
    logic [NCH-1:0] ch_err = '0;
    logic [NCH-1:0] ch_req_en;
    logic [NCH-1:0] ch_start;
    logic [NCH-1:0] ch_clr_done;
    logic [31:0]    ctrl_word;
    logic           irq_xfer;
    logic           irq_err;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    logic [31:0] m_ctrl = '0, m_req = '0, m_eie = '0, m_int = '0, m_err = '0;
    logic [4:0]  m_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ctl_regbank #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ch_done(ch_done), .ch_err(ch_err),
        .ch_req_en(ch_req_en), .ch_start(ch_start), .ch_clr_done(ch_clr_done),
        .ctrl_word(ctrl_word), .irq_xfer(irq_xfer), .irq_err(irq_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // One bus cycle with optional engine pulses; returns after the edge
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input logic [31:0] dn, input logic [31:0] er);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
        ch_done = dn; ch_err = er;
        @(negedge clk);
        bus_wr = 1'b0; ch_done = '0; ch_err = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] v);
        bus_addr = a; bus_size = sz;
        #1 v = bus_rdata;
    endtask

    function automatic logic [31:0] lowest_bit(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
        return 0;
    endfunction

    function automatic logic [31:0] model_word(input logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h04: return {|m_err, 26'h0, m_last};
            8'h0C: return m_req;
            8'h14: return m_eie;
            8'h24: return m_int;
            8'h2C: return m_err;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_err(input logic [31:0] er);
        if (er != 0) begin
            m_last = lowest_bit(er)[4:0];
            m_err  = m_err | er;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        foreach (w[i]) begin end
        for (int k = 0; k < 12; k++) begin
            rd(8'(k * 4), 2'd2, v);
            chk("R1 reg reset", v, 32'h0);
        end
        chk("R1 outputs reset", {ch_req_en | ch_start | ch_clr_done}, 32'h0);
        chk("R1 irq reset", {30'h0, irq_xfer, irq_err}, 32'h0);

        // R2: set-request sweep, little-endian, junk in upper bits
        for (int c = 0; c < NCH; c++) begin
            cyc(1'b1, 8'h1B, 2'd0, {24'h0, 3'(c + 5), 5'(c)}, '0, '0);
            m_req[c] = 1'b1;
            chk("R2 set req", ch_req_en, m_req);
        end
        // R2/R10: clear-request sweep in big-endian view (0x1A ^ 3)
        big_endian = 1'b1;
        for (int c = 0; c < NCH; c += 3) begin
            cyc(1'b1, 8'h19, 2'd0, {24'h0, 3'(c), 5'(c)}, '0, '0);
            m_req[c] = 1'b0;
            chk("R2 R10 clr req BE", ch_req_en, m_req);
        end
        big_endian = 1'b0;
        rd(8'h0C, 2'd2, v);
        chk("R2 req readback", v, m_req);

        // R3: error-interrupt enable ports, LE for even, BE for odd
        for (int c = 0; c < NCH; c++) begin
            big_endian = c[0];
            cyc(1'b1, c[0] ? 8'h1A : 8'h19, 2'd0, 32'(c), '0, '0);
            m_eie[c] = 1'b1;
        end
        for (int c = 1; c < NCH; c += 4) begin
            big_endian = 1'b0;
            cyc(1'b1, 8'h18, 2'd0, 32'(c), '0, '0);
            m_eie[c] = 1'b0;
        end
        big_endian = 1'b0;
        rd(8'h14, 2'd2, v);
        chk("R3 eie mask", v, m_eie);
        chk("R3 req untouched", ch_req_en, m_req);

        // R4/R10: word loads in both views
        cyc(1'b1, 8'h0C, 2'd2, 32'hA5C3_1E07, '0, '0);
        m_req = 32'hA5C3_1E07;
        chk("R4 req word LE", ch_req_en, m_req);
        big_endian = 1'b1;
        cyc(1'b1, 8'h14, 2'd2, 32'h1234_5678, '0, '0);
        m_eie = 32'h7856_3412;
        rd(8'h14, 2'd2, v);
        chk("R4 R10 eie BE readback", v, 32'h1234_5678);
        big_endian = 1'b0;
        rd(8'h14, 2'd2, v);
        chk("R4 R10 eie LE view", v, m_eie);

        // R10/R11: every byte and halfword lane in both views
        for (int be = 0; be < 2; be++) begin
            big_endian = be[0];
            for (int a = 0; a < 4; a++) begin
                rd(8'(8'h0C + a), 2'd0, v);
                chk("R10 R11 byte lane", v, (m_req >> (8 * (be != 0 ? 3 - a : a))) & 32'hFF);
            end
            for (int h = 0; h < 2; h++) begin
                rd(8'(8'h0C + 2 * h), 2'd1, v);
                chk("R10 R11 half lane", v, (m_req >> (16 * (be != 0 ? 1 - h : h))) & 32'hFFFF);
            end
        end
        big_endian = 1'b0;

        // R11: ignored writes and size code 3
        cyc(1'b1, 8'h0C, 2'd1, 32'h0000_FFFF, '0, '0);
        cyc(1'b1, 8'h0E, 2'd2, 32'hFFFF_FFFF, '0, '0);
        cyc(1'b1, 8'h0C, 2'd3, 32'hFFFF_FFFF, '0, '0);
        cyc(1'b1, 8'h24, 2'd2, 32'hFFFF_FFFF, '0, '0);
        cyc(1'b1, 8'h2C, 2'd2, 32'hFFFF_FFFF, '0, '0);
        chk("R11 req after ignored writes", ch_req_en, m_req);
        rd(8'h24, 2'd2, v);
        chk("R11 ipend read-only", v, 32'h0);
        chk("R11 no irq from ignored writes", {30'h0, irq_xfer, irq_err}, 32'h0);
        rd(8'h0C, 2'd3, v);
        chk("R11 size3 read", v, 32'h0);

        // R5: control keep mask
        cyc(1'b1, 8'h00, 2'd2, 32'hFFFF_FFFF, '0, '0);
        rd(8'h00, 2'd2, v);
        chk("R5 ctrl all ones", v, 32'h0003_00FE);
        cyc(1'b1, 8'h00, 2'd2, 32'h1235_5679, '0, '0);
        m_ctrl = 32'h1235_5679 & 32'h0003_00FE;
        chk("R5 ctrl_word port", ctrl_word, m_ctrl);

        // R6: done pulses set pending, clear port clears, collision keeps
        cyc(1'b0, 8'h00, 2'd0, 0, 32'h8000_0011, '0);
        m_int = 32'h8000_0011;
        rd(8'h24, 2'd2, v);
        chk("R6 ipend set", v, m_int);
        chk("R6 irq_xfer high", {31'h0, irq_xfer}, 32'h1);
        cyc(1'b1, 8'h1F, 2'd0, 32'd4, 32'h0000_0010, '0);
        rd(8'h24, 2'd2, v);
        chk("R6 collision keeps bit", v, m_int);
        for (int c = 0; c < NCH; c++) begin
            cyc(1'b1, 8'h1F, 2'd0, 32'(c), '0, '0);
            m_int[c] = 1'b0;
            rd(8'h24, 2'd2, v);
            chk("R6 clear int", v, m_int);
            chk("R6 irq_xfer OR", {31'h0, irq_xfer}, {31'h0, |m_int});
        end

        // R7/R8: single-channel error sweep against the enable mask
        for (int c = 0; c < NCH; c++) begin
            cyc(1'b0, 8'h00, 2'd0, 0, '0, 32'h1 << c);
            model_err(32'h1 << c);
            rd(8'h04, 2'd2, v);
            chk("R7 err status", v, model_word(8'h04));
            chk("R8 irq_err", {31'h0, irq_err}, {31'h0, |(m_err & m_eie)});
            cyc(1'b1, 8'h1E, 2'd0, 32'(c), '0, '0);
            m_err[c] = 1'b0;
            rd(8'h2C, 2'd2, v);
            chk("R7 err clear", v, m_err);
        end
        // R7: multi-channel pulse records the lowest; collision keeps bit
        cyc(1'b1, 8'h1E, 2'd0, 32'd19, '0, 32'h0009_0000);
        model_err(32'h0009_0000);
        rd(8'h04, 2'd2, v);
        chk("R7 lowest channel and valid", v, 32'h8000_0010);
        rd(8'h2C, 2'd2, v);
        chk("R7 collision keeps err", v, m_err);
        // R8: enable gates the error line
        cyc(1'b1, 8'h14, 2'd2, 32'h0, '0, '0);
        m_eie = '0;
        chk("R8 irq_err masked", {31'h0, irq_err}, 32'h0);
        cyc(1'b1, 8'h19, 2'd0, 32'd16, '0, '0);
        m_eie[16] = 1'b1;
        chk("R8 irq_err enabled", {31'h0, irq_err}, 32'h1);

        // R9: start and clear-done strobes, one cycle each
        for (int c = 0; c < NCH; c++) begin
            cyc(1'b1, 8'h1D, 2'd0, {24'h0, 3'b111, 5'(c)}, '0, '0);
            chk("R9 start pulse", ch_start, 32'h1 << c);
            chk("R9 no clr_done", ch_clr_done, 32'h0);
            @(negedge clk);
            chk("R9 start one cycle", ch_start, 32'h0);
            cyc(1'b1, 8'h1C, 2'd0, 32'(c), '0, '0);
            chk("R9 clr_done pulse", ch_clr_done, 32'h1 << c);
            @(negedge clk);
            chk("R9 clr_done one cycle", ch_clr_done, 32'h0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule